// File: doc/BRIEF.md
# Clock Gate Enable Register Bank

This block holds the on/off state of every system clock gate and every peripheral clock gate in a clock controller. It also holds a small divider code for each peripheral. Software reaches it through a plain word-addressed port: a write strobe with address and data, plus a combinational read path. The gating cells and clock muxes sit elsewhere. This block only drives their enable bits and divider codes.

System clocks and peripheral clocks each have their own registers. A write of ones to a set register turns those gates on, and a write of ones to a clear register turns them off. A status register returns the present state. Peripheral gates with index 32 and above appear in a second status word and have their own clear register.

A command register changes one peripheral's enable and divider in a single write. A write with the command bit low changes no gate or divider. It only chooses which peripheral that register reports when read. A divider code k means the peripheral runs at its parent rate divided by 2^k, rounded up.

Top module: `cg_gate_bank`

Register word addresses: 0 system set, 1 system clear, 2 system status, 3 peripheral set (index 0..31), 4 peripheral clear (0..31), 5 peripheral status (0..31), 6 peripheral clear (32 and up), 7 peripheral status (32 and up), 8 peripheral command. Addresses 9 to 15 are unmapped.

## Requirements
- R1: After reset, all system enables, peripheral enables and divider codes are zero, and every register reads zero.
- R2: A write to address 0 sets each system enable whose data bit is 1, from the next clock edge on. Data bits that are 0 leave their enables unchanged. Status at address 2 reads the system enables in bits NUM_SYS-1:0.
- R3: A write to address 1 clears each system enable whose data bit is 1. Data bits that are 0 leave their enables unchanged.
- R4: Writes to addresses 3 and 4 set and clear peripheral enables 0..31 bit for bit, with the same write-one rule. Address 5 reads peripheral enables 0..31.
- R5: A write to address 6 clears peripheral enable n (n >= 32) when data bit n-32 is 1. Address 7 reads peripheral enable n at bit n mod 32.
- R6: A write to address 8 with bit 31 set loads bit 28 into the enable of peripheral ID = bits 5:0, and bits 17:16 into its divider code. It leaves every other peripheral unchanged.
- R7: A write to address 8 with bit 31 clear changes no enable and no divider code.
- R8: Every write to address 8 records ID = bits 5:0. A read of address 8 returns that ID in bits 5:0, its divider code in bits 17:16 and its enable in bit 28, with all other bits zero.
- R9: Writes to the status addresses (2, 5, 7) and to unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| addr | input | 4 | Word address for both write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| sys_gate_en | output | NUM_SYS | System clock gate enables |
| per_gate_en | output | NUM_PER | Peripheral clock gate enables |
| per_div | output | NUM_PER*DIV_W | Peripheral divider codes, DIV_W bits per ID, ID 0 lowest |

## Verification
The hardest state to reach from the ports is a command write to a high peripheral ID followed by a clear through the second clear word. It must hit exactly the bit at ID minus 32 while the divider code survives. A second hard case is a command-clear write that moves the read selection without touching any gate. Directed writes to ID 40 and to the top ID set up both cases. A random phase with a fixed seed then mixes set, clear, command, selection-only, status-address and unmapped writes across all 64 IDs, and reads every status word and the command register back after each write.

// File: rtl/cg_pkg.sv
package cg_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_SYS_SET  = 4'd0;
  localparam logic [ADDR_W-1:0] A_SYS_CLR  = 4'd1;
  localparam logic [ADDR_W-1:0] A_SYS_STAT = 4'd2;
  localparam logic [ADDR_W-1:0] A_PER_SET  = 4'd3;
  localparam logic [ADDR_W-1:0] A_PER_CLR  = 4'd4;
  localparam logic [ADDR_W-1:0] A_PER_STAT = 4'd5;
  localparam logic [ADDR_W-1:0] A_PHI_CLR  = 4'd6;
  localparam logic [ADDR_W-1:0] A_PHI_STAT = 4'd7;
  localparam logic [ADDR_W-1:0] A_PCMD     = 4'd8;

  localparam int unsigned PC_CMD_BIT = 31;
  localparam int unsigned PC_EN_BIT  = 28;
  localparam int unsigned PC_DIV_LSB = 16;
endpackage

// File: rtl/cg_rst_sync.sv
module cg_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/cg_w1_bank.sv
module cg_w1_bank #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     set_mask,
  input  logic [N-1:0]     clr_mask,
  input  logic             cmd_we,
  input  logic [IDX_W-1:0] cmd_idx,
  input  logic             cmd_val,
  output logic [N-1:0]     en_q
);
  logic [N-1:0] en_d;
  logic         upd;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      en_d[i] = en_q[i];
      if (set_mask[i]) en_d[i] = 1'b1;
      if (clr_mask[i]) en_d[i] = 1'b0;
      if (cmd_we && (cmd_idx == IDX_W'(i))) en_d[i] = cmd_val;
    end
  end

  assign upd = (|set_mask) | (|clr_mask) | cmd_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   en_q <= '0;
    else if (upd) en_q <= en_d;
  end
endmodule

// File: rtl/cg_div_bank.sv
module cg_div_bank #(
  parameter int unsigned N     = 64,
  parameter int unsigned DIV_W = 2,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_we,
  input  logic [IDX_W-1:0]   cmd_idx,
  input  logic [DIV_W-1:0]   cmd_div,
  output logic [N*DIV_W-1:0] div_q
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    logic hit;
    assign hit = cmd_we && (cmd_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   div_q[i*DIV_W +: DIV_W] <= '0;
      else if (hit) div_q[i*DIV_W +: DIV_W] <= cmd_div;
    end
  end
endmodule

// File: rtl/cg_gate_bank.sv
module cg_gate_bank
  import cg_pkg::*;
#(
  parameter int unsigned NUM_SYS = 16,
  parameter int unsigned NUM_PER = 64,
  parameter int unsigned DIV_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [3:0]               addr,
  input  logic [31:0]              wdata,
  output logic [31:0]              rdata,
  output logic [NUM_SYS-1:0]       sys_gate_en,
  output logic [NUM_PER-1:0]       per_gate_en,
  output logic [NUM_PER*DIV_W-1:0] per_div
);
  localparam int unsigned ID_W  = $clog2(NUM_PER);
  localparam int unsigned HI_N  = NUM_PER - 32;
  localparam int unsigned SYS_W = (NUM_SYS > 1) ? $clog2(NUM_SYS) : 1;

  logic               rst_n_s;
  logic [NUM_SYS-1:0] sys_set, sys_clr;
  logic [NUM_PER-1:0] per_set, per_clr;
  logic               cmd_wr, cmd_we;
  logic [ID_W-1:0]    cmd_idx;
  logic [ID_W-1:0]    sel_d, sel_q;

  cg_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  // write decode
  always_comb begin
    sys_set = '0;
    sys_clr = '0;
    per_set = '0;
    per_clr = '0;
    if (wr_en && addr == A_SYS_SET) sys_set = wdata[NUM_SYS-1:0];
    if (wr_en && addr == A_SYS_CLR) sys_clr = wdata[NUM_SYS-1:0];
    if (wr_en && addr == A_PER_SET) per_set[31:0] = wdata;
    if (wr_en && addr == A_PER_CLR) per_clr[31:0] = wdata;
    if (wr_en && addr == A_PHI_CLR) per_clr[NUM_PER-1:32] = wdata[HI_N-1:0];
  end

  assign cmd_wr  = wr_en && (addr == A_PCMD);
  assign cmd_we  = cmd_wr && wdata[PC_CMD_BIT];
  assign cmd_idx = wdata[ID_W-1:0];

  cg_w1_bank #(.N(NUM_SYS), .IDX_W(SYS_W)) u_sys (
    .clk(clk), .rst_n(rst_n_s),
    .set_mask(sys_set), .clr_mask(sys_clr),
    .cmd_we(1'b0), .cmd_idx('0), .cmd_val(1'b0),
    .en_q(sys_gate_en)
  );

  cg_w1_bank #(.N(NUM_PER), .IDX_W(ID_W)) u_per (
    .clk(clk), .rst_n(rst_n_s),
    .set_mask(per_set), .clr_mask(per_clr),
    .cmd_we(cmd_we), .cmd_idx(cmd_idx), .cmd_val(wdata[PC_EN_BIT]),
    .en_q(per_gate_en)
  );

  cg_div_bank #(.N(NUM_PER), .DIV_W(DIV_W), .IDX_W(ID_W)) u_div (
    .clk(clk), .rst_n(rst_n_s),
    .cmd_we(cmd_we), .cmd_idx(cmd_idx),
    .cmd_div(wdata[PC_DIV_LSB +: DIV_W]),
    .div_q(per_div)
  );

  // read-back selection: next state
  always_comb begin
    sel_d = sel_q;
    if (cmd_wr) sel_d = cmd_idx;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    sel_q <= '0;
    else if (cmd_wr) sel_q <= sel_d;
  end

  // read mux
  always_comb begin
    rdata = '0;
    case (addr)
      A_SYS_STAT: rdata[NUM_SYS-1:0] = sys_gate_en;
      A_PER_STAT: rdata = per_gate_en[31:0];
      A_PHI_STAT: rdata[HI_N-1:0] = per_gate_en[NUM_PER-1:32];
      A_PCMD: begin
        rdata[ID_W-1:0]              = sel_q;
        rdata[PC_DIV_LSB +: DIV_W]   = per_div[int'(sel_q)*DIV_W +: DIV_W];
        rdata[PC_EN_BIT]             = per_gate_en[sel_q];
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/cg_gate_bank_chk.sv
module cg_gate_bank_chk
  import cg_pkg::*;
#(
  parameter int unsigned NUM_SYS = 16,
  parameter int unsigned NUM_PER = 64,
  parameter int unsigned DIV_W   = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [3:0]               addr,
  input logic [31:0]              wdata,
  input logic [31:0]              rdata,
  input logic [NUM_SYS-1:0]       sys_gate_en,
  input logic [NUM_PER-1:0]       per_gate_en,
  input logic [NUM_PER*DIV_W-1:0] per_div
);
  localparam int unsigned ID_W = $clog2(NUM_PER);
  localparam int unsigned HI_N = NUM_PER - 32;

  always_comb begin
    if (!rst_n) begin
      assert_reset_state_R1: assert (sys_gate_en == '0 && per_gate_en == '0 && per_div == '0);
    end
  end

  assert_sys_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SYS_SET) |=>
      ((sys_gate_en & $past(wdata[NUM_SYS-1:0])) == $past(wdata[NUM_SYS-1:0])));

  assert_sys_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SYS_CLR) |=> ((sys_gate_en & $past(wdata[NUM_SYS-1:0])) == '0));

  assert_sys_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == A_SYS_SET || addr == A_SYS_CLR)) |=> $stable(sys_gate_en));

  assert_per_set_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_PER_SET) |=> ((per_gate_en[31:0] & $past(wdata)) == $past(wdata)));

  assert_per_clr_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_PHI_CLR) |=>
      ((per_gate_en[NUM_PER-1:32] & $past(wdata[HI_N-1:0])) == '0));

  assert_cmd_apply_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_PCMD && wdata[PC_CMD_BIT]) |=>
      (per_gate_en[$past(wdata[ID_W-1:0])] == $past(wdata[PC_EN_BIT])));

  assert_cmd_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_PCMD && !wdata[PC_CMD_BIT]) |=>
      ($stable(per_gate_en) && $stable(per_div)));

  assert_ro_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_SYS_STAT || addr == A_PER_STAT || addr == A_PHI_STAT || addr > A_PCMD)) |=>
      ($stable(sys_gate_en) && $stable(per_gate_en) && $stable(per_div)));
endmodule

bind cg_gate_bank cg_gate_bank_chk #(.NUM_SYS(NUM_SYS), .NUM_PER(NUM_PER), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
  .sys_gate_en(sys_gate_en), .per_gate_en(per_gate_en), .per_div(per_div)
);

// File: tb/cg_gate_bank_tb.sv
`timescale 1ns/100ps
module cg_gate_bank_tb;
  localparam int NUM_SYS = 16;
  localparam int NUM_PER = 64;
  localparam int DIV_W   = 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [3:0]   addr;
  logic [31:0]  wdata;
  logic [31:0]  rdata;
  logic [NUM_SYS-1:0]       sys_gate_en;
  logic [NUM_PER-1:0]       per_gate_en;
  logic [NUM_PER*DIV_W-1:0] per_div;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [NUM_SYS-1:0]       sys_m;
  logic [NUM_PER-1:0]       per_m;
  logic [NUM_PER*DIV_W-1:0] div_m;
  logic [5:0]               sel_m;

  always #4 clk = ~clk;

  cg_gate_bank #(.NUM_SYS(NUM_SYS), .NUM_PER(NUM_PER), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .sys_gate_en(sys_gate_en), .per_gate_en(per_gate_en), .per_div(per_div)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pcmd_word(input bit cmd, input bit en,
                                            input logic [1:0] dv, input logic [5:0] id);
    return {cmd, 2'b00, en, 10'd0, dv, 10'd0, id};
  endfunction

  // reference model update from the requirement text
  task automatic model(input logic [3:0] a, input logic [31:0] d);
    case (a)
      4'd0: sys_m = sys_m | d[NUM_SYS-1:0];                          // R2
      4'd1: sys_m = sys_m & ~d[NUM_SYS-1:0];                         // R3
      4'd3: per_m[31:0] = per_m[31:0] | d;                           // R4
      4'd4: per_m[31:0] = per_m[31:0] & ~d;                          // R4
      4'd6: per_m[63:32] = per_m[63:32] & ~d;                        // R5
      4'd8: begin
        sel_m = d[5:0];                                              // R8
        if (d[31]) begin                                             // R6
          per_m[d[5:0]] = d[28];
          div_m[int'(d[5:0])*DIV_W +: DIV_W] = d[17:16];
        end
      end
      default: ;                                                     // R9
    endcase
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic check_all(input string req);
    logic [31:0] v;
    logic [31:0] e;
    chk({req, " sys_gate_en"}, 128'(sys_gate_en), 128'(sys_m));
    chk({req, " per_gate_en"}, 128'(per_gate_en), 128'(per_m));
    chk({req, " per_div"}, per_div, div_m);
    rd(4'd2, v); chk({req, " sys status R2"}, 128'(v), 128'({16'd0, sys_m}));
    rd(4'd5, v); chk({req, " per status R4"}, 128'(v), 128'(per_m[31:0]));
    rd(4'd7, v); chk({req, " hi status R5"}, 128'(v), 128'(per_m[63:32]));
    e = pcmd_word(1'b0, per_m[sel_m], div_m[int'(sel_m)*DIV_W +: DIV_W], sel_m);
    rd(4'd8, v); chk({req, " cmd readback R8"}, 128'(v), 128'(e));
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input string req);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    model(a, d);
    check_all(req);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [3:0]  a;
    void'($urandom(32'd1234));
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    sys_m = '0; per_m = '0; div_m = '0; sel_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 reset");

    wr(4'd0, 32'h0000_A5F0, "R2 sys set");
    wr(4'd0, 32'h0000_0000, "R2 zero bits no effect");
    wr(4'd1, 32'h0000_0530, "R3 sys clear");
    wr(4'd3, 32'hDEAD_BEEF, "R4 per set");
    wr(4'd4, 32'h0F0F_0000, "R4 per clear");
    wr(4'd8, pcmd_word(1'b1, 1'b1, 2'd3, 6'd40), "R6 cmd id 40");
    wr(4'd8, pcmd_word(1'b1, 1'b1, 2'd2, 6'd63), "R6 cmd id 63");
    wr(4'd8, pcmd_word(1'b1, 1'b0, 2'd1, 6'd5), "R6 cmd id 5 off");
    wr(4'd8, pcmd_word(1'b0, 1'b0, 2'd0, 6'd40), "R7 select only");
    wr(4'd6, 32'h0000_0100, "R5 hi clear id 40");
    wr(4'd6, 32'h0000_0000, "R5 zero bits no effect");
    wr(4'd8, pcmd_word(1'b0, 1'b1, 2'd3, 6'd63), "R7 R8 select 63");
    wr(4'd2, 32'hFFFF_FFFF, "R9 write sys status");
    wr(4'd7, 32'hFFFF_FFFF, "R9 write hi status");
    wr(4'd12, 32'hFFFF_FFFF, "R9 unmapped");

    for (int i = 0; i < 1500; i++) begin
      a = 4'($urandom_range(0, 15));
      if (a > 4'd9 && ($urandom_range(0, 3) != 0)) a = 4'd8;
      d = $urandom();
      wr(a, d, "R2 R3 R4 R5 R6 R7 R9 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule